// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This peripheral watches forty-eight digital input lines and interrupts the host when any line in an enabled group changes level. The lines are split into six groups of eight, where group n holds lines 8n to 8n+7. Software reaches the block through an eight-byte register window with byte reads and writes. Six of the offsets return the current (synchronised) line levels. One offset takes the group enable mask on a write, and on a read it returns the latched group status.

Every line goes through a two-flop synchroniser. A change is found by comparing each synchronised line with its own value one clock earlier, so rising and falling edges count the same. A change in an enabled group latches that group's status bit, and the interrupt output stays high while any status bit is held. Reading the status offset returns the latched groups with an active-low pending flag, then clears the status and drops the interrupt. If a new change arrives on the same clock edge as that clearing read, the new change is kept.

A small state machine tracks the interrupt side of the block. It has three states:
- `ST_DISARMED`: the mask is zero and nothing is pending.
- `ST_ARMED`: the mask is nonzero and nothing is pending.
- `ST_PENDING`: at least one status bit is latched, and the interrupt output is high.

Its transitions are:
- `arm`: a nonzero mask is written, going from DISARMED to ARMED.
- `disarm`: an all-zero mask is written, going from ARMED to DISARMED.
- `fire`: an enabled group changes, going from DISARMED or ARMED to PENDING.
- `ack_rearm`: a clearing read with no new change while the mask is nonzero, going from PENDING to ARMED.
- `ack_idle`: the same clearing read while the mask is zero, going from PENDING to DISARMED.
- `hold`: a clearing read on the same edge as a new enabled change, staying in PENDING.

Top module: `cos_irq_ctrl`

## Requirements
- R1: A read at offsets 0, 1 and 2 returns synchronised lines 0–7, 8–15 and 16–23. A read at offsets 4, 5 and 6 returns lines 24–31, 32–39 and 40–47. In each byte, bit k is the lowest line of that byte plus k. A line change shows up in these reads from the second rising edge after the change.
- R2: A read at offset 3 returns 0x00. Writes to offsets 0 to 6 have no effect on any later read.
- R3: A write to offset 7 loads wdata bits 5:0 as the enable mask, where bit n enables group n. A change on any line of an enabled group sets status bit n at the third rising edge after the line changes.
- R4: Rising and falling edges of a line both set the status bit of its group.
- R5: A change in a group whose enable bit is 0 never sets that group's status bit.
- R6: Writing a mask with a group's enable bit at 0 does not clear a status bit that is already latched for that group.
- R7: A read at offset 7 returns the status in bits 5:0. Bit 6 is 0 when an interrupt is pending and 1 when none is. Bit 7 is always 0.
- R8: A read at offset 7 (rd_en high) clears all status bits and deasserts irq at the same rising edge. A group change landing on that same edge stays latched.
- R9: irq is high exactly while at least one status bit is set.
- R10: Reset clears the mask and the status and deasserts irq, so offset 7 reads 0x40. After reset, changes raise no interrupt until a mask is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Byte offset within the register window |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| rd_en | input | 1 | Read strobe; with offset 7 it clears status at the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, a combinational function of addr and current state |
| din | input | 48 | Asynchronous input lines |
| irq | output | 1 | Interrupt, high while any group status is latched |

## Verification
A line change is visible on the port bytes after two rising edges. It reaches the status byte and irq after three. rdata follows addr combinationally, and a clearing read takes effect at the edge that samples rd_en.

The bench drives inputs on the falling edge and waits for exactly three rising edges after each line change before reading. One directed test checks the status byte after the second edge, where it must not have changed yet, and again after the third, where it must have. Another asserts the clearing read on the very edge where a new change is detected, then checks that only the new group survives.

// File: rtl/cos_pkg.sv
package cos_pkg;

    localparam int GRP_W      = 8;
    localparam int NUM_GRP    = 6;
    localparam int NUM_IN     = GRP_W * NUM_GRP;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int SYNC_DEPTH = 2;

    // Window layout: three line bytes, a hole, three line bytes, control byte
    localparam int                 BYTES_PER_PORT = 3;
    localparam logic [ADDR_W-1:0]  OFS_HOLE       = 3'd3;
    localparam logic [ADDR_W-1:0]  OFS_CTRL       = 3'd7;
    localparam int                 PEND_POS       = 6;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_PENDING  = 2'd2
    } cos_state_e;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int WIDTH  = 48,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cos_change_det.sv
module cos_change_det #(
    parameter int GROUPS = 6,
    parameter int GW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GROUPS*GW-1:0] cur,
    output logic [GROUPS-1:0]    grp_chg
);

    localparam int N = GROUPS * GW;

    logic [N-1:0] prev;
    logic [N-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    // Any difference counts: rising and falling alike
    assign diff = cur ^ prev;

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            assign grp_chg[g] = |diff[g*GW +: GW];
        end
    endgenerate

endmodule

// File: rtl/cos_irq_fsm.sv
module cos_irq_fsm
    import cos_pkg::*;
#(
    parameter int GROUPS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] grp_chg,
    input  logic              mask_wr,
    input  logic [GROUPS-1:0] mask_wdata,
    input  logic              clr,
    output logic [GROUPS-1:0] mask_q,
    output logic [GROUPS-1:0] status_q,
    output logic              irq
);

    cos_state_e        state_q, state_d;
    logic [GROUPS-1:0] set_vec;
    logic [GROUPS-1:0] status_d;
    logic [GROUPS-1:0] mask_d;
    logic              set_any;

    assign mask_d   = mask_wr ? mask_wdata : mask_q;
    assign set_vec  = grp_chg & mask_q;
    assign set_any  = |set_vec;
    // A new change beats a clearing read on the same edge
    assign status_d = (clr ? '0 : status_q) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            mask_q   <= mask_d;
            status_q <= status_d;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (set_any)           state_d = ST_PENDING;   // fire
                else if (|mask_d)      state_d = ST_ARMED;     // arm
            end
            ST_ARMED: begin
                if (set_any)           state_d = ST_PENDING;   // fire
                else if (!(|mask_d))   state_d = ST_DISARMED;  // disarm
            end
            ST_PENDING: begin
                if (clr && !set_any) begin
                    if (|mask_d)       state_d = ST_ARMED;     // ack_rearm
                    else               state_d = ST_DISARMED;  // ack_idle
                end
                // otherwise hold
            end
            default:                   state_d = ST_DISARMED;
        endcase
    end

    // Outputs
    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            ST_PENDING: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/cos_bus_if.sv
module cos_bus_if
    import cos_pkg::*;
#(
    parameter int GROUPS = 6,
    parameter int GW     = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [GROUPS*GW-1:0] din_s,
    input  logic [GROUPS-1:0]    status_q,
    input  logic                 irq,
    output logic [DATA_W-1:0]    rdata,
    output logic                 mask_wr,
    output logic [GROUPS-1:0]    mask_wdata,
    output logic                 clr
);

    logic             is_ctrl;
    logic             unused_wdata;
    logic [ADDR_W-1:0] byte_idx;

    assign is_ctrl    = (addr == OFS_CTRL);
    assign mask_wr    = wr_en && is_ctrl;
    assign clr        = rd_en && is_ctrl;
    assign mask_wdata = wdata[GROUPS-1:0];
    assign unused_wdata = ^wdata[DATA_W-1:GROUPS];

    // Second port sits one byte above the hole
    assign byte_idx = (addr <= ADDR_W'(BYTES_PER_PORT - 1)) ? addr : addr - 1'b1;

    always_comb begin
        rdata = '0;
        if (is_ctrl) begin
            rdata[GROUPS-1:0] = status_q;
            rdata[PEND_POS]   = ~irq;
        end else if (addr != OFS_HOLE) begin
            rdata = din_s[int'(byte_idx)*GW +: GW];
        end
    end

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int GROUPS = cos_pkg::NUM_GRP,
    parameter int GW     = cos_pkg::GRP_W,
    parameter int STAGES = cos_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [47:0]       din,
    output logic              irq
);

    localparam int N = GROUPS * GW;

    logic [N-1:0]      din_s;
    logic [GROUPS-1:0] grp_chg;
    logic [GROUPS-1:0] mask_q;
    logic [GROUPS-1:0] status_q;
    logic [GROUPS-1:0] mask_wdata;
    logic              mask_wr;
    logic              clr;

    cos_sync #(.WIDTH(N), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (din),
        .q     (din_s)
    );

    cos_change_det #(.GROUPS(GROUPS), .GW(GW)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (din_s),
        .grp_chg (grp_chg)
    );

    cos_irq_fsm #(.GROUPS(GROUPS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_chg    (grp_chg),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .clr        (clr),
        .mask_q     (mask_q),
        .status_q   (status_q),
        .irq        (irq)
    );

    cos_bus_if #(.GROUPS(GROUPS), .GW(GW)) u_bus (
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .din_s      (din_s),
        .status_q   (status_q),
        .irq        (irq),
        .rdata      (rdata),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .clr        (clr)
    );

endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
    parameter int GROUPS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              irq,
    input logic [GROUPS-1:0] mask_q,
    input logic [GROUPS-1:0] status_q,
    input logic [GROUPS-1:0] grp_chg
);

    // R3: an enabled change raises the interrupt on the next edge
    a_r3_fire_on_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grp_chg & mask_q)) |=> irq);

    // R5: no status bit appears for a group that was disabled
    a_r5_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));

    // R6: a mask write alone never drops a latched bit
    a_r6_keep_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7 && !rd_en) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8: a clearing read with no simultaneous change empties the status
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd7 && ((grp_chg & mask_q) == '0)) |=> (status_q == '0 && !irq));

    // R9: interrupt state agrees with the status register
    a_r9_irq_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (irq == (status_q != '0)));

endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.GROUPS(GROUPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .irq      (irq),
    .mask_q   (mask_q),
    .status_q (status_q),
    .grp_chg  (grp_chg)
);

// File: tb/cos_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cos_irq_ctrl_bench;

    localparam int NV = 32;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_DIN = 2'd2;

    // {op, addr, data48, expected byte}
    localparam logic [60:0] VEC [NV] = '{
        {OP_RD,  3'd7, 48'h0,            8'h40}, // R10 reset value
        {OP_WR,  3'd7, 48'h05,           8'h00}, // R3 enable groups 0,2
        {OP_DIN, 3'd0, 48'h000000000001, 8'h00}, // rise in group 0
        {OP_RD,  3'd7, 48'h0,            8'h01}, // R3 R7
        {OP_RD,  3'd7, 48'h0,            8'h40}, // R8 cleared
        {OP_DIN, 3'd0, 48'h000000000000, 8'h00}, // fall in group 0
        {OP_RD,  3'd7, 48'h0,            8'h01}, // R4
        {OP_DIN, 3'd0, 48'h000000000100, 8'h00}, // group 1 disabled
        {OP_RD,  3'd7, 48'h0,            8'h40}, // R5
        {OP_DIN, 3'd0, 48'h000000010100, 8'h00}, // group 2
        {OP_WR,  3'd7, 48'h00,           8'h00}, // R6 disable all
        {OP_RD,  3'd7, 48'h0,            8'h04}, // R6 still latched
        {OP_RD,  3'd7, 48'h0,            8'h40},
        {OP_DIN, 3'd0, 48'h123456ABCDEF, 8'h00},
        {OP_RD,  3'd0, 48'h0,            8'hEF}, // R1
        {OP_RD,  3'd1, 48'h0,            8'hCD},
        {OP_RD,  3'd2, 48'h0,            8'hAB},
        {OP_RD,  3'd3, 48'h0,            8'h00}, // R2 hole
        {OP_RD,  3'd4, 48'h0,            8'h56},
        {OP_RD,  3'd5, 48'h0,            8'h34},
        {OP_RD,  3'd6, 48'h0,            8'h12},
        {OP_WR,  3'd2, 48'hFF,           8'h00}, // R2 write ignored
        {OP_WR,  3'd3, 48'hFF,           8'h00},
        {OP_RD,  3'd2, 48'h0,            8'hAB},
        {OP_RD,  3'd3, 48'h0,            8'h00},
        {OP_RD,  3'd7, 48'h0,            8'h40}, // R5 mask was zero
        {OP_WR,  3'd7, 48'h3F,           8'h00},
        {OP_DIN, 3'd0, 48'h123456ABCDEE, 8'h00},
        {OP_RD,  3'd7, 48'h0,            8'h01},
        {OP_DIN, 3'd0, 48'h923456ABCCEE, 8'h00}, // groups 1 and 5
        {OP_RD,  3'd7, 48'h0,            8'h22},
        {OP_RD,  3'd7, 48'h0,            8'h40}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] din = '0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cos_irq_ctrl u_cos_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .din(din), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic peek(input string tag, input logic [7:0] exp);
        addr = 3'd7; rd_en = 1'b0;
        #1;
        check({tag, " status"}, rdata, exp);
        check({tag, " irq"}, {7'd0, irq}, {7'd0, ~exp[6]});
    endtask

    task automatic do_read(input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        if (a == 3'd7) begin
            check("R7 status byte", rdata, exp);
            check("R9 irq", {7'd0, irq}, {7'd0, ~exp[6]});
        end else begin
            check("R1 R2 port byte", rdata, exp);
        end
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic set_din(input logic [47:0] v);
        @(negedge clk);
        din = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][60:59])
                OP_RD:  do_read(VEC[i][58:56], VEC[i][7:0]);
                OP_WR:  do_write(VEC[i][58:56], VEC[i][15:8]);
                default: set_din(VEC[i][55:8]);
            endcase
        end

        // R3 exact latency: nothing after the second edge, set after the third
        @(negedge clk) din = 48'h923456ABCCEF;
        @(posedge clk); @(posedge clk);
        @(negedge clk) peek("R3 before third edge", 8'h40);
        @(posedge clk);
        @(negedge clk) peek("R3 after third edge", 8'h01);
        do_read(3'd7, 8'h01);

        // R8 change detected on the very edge of the clearing read
        set_din(48'h923456ABCCEE);
        @(negedge clk) din = 48'h923457ABCCEE;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = 3'd7; rd_en = 1'b1;
        #1 check("R8 read before collision", rdata, 8'h01);
        @(posedge clk);
        #1 rd_en = 1'b0;
        @(negedge clk) peek("R8 new change kept", 8'h08);
        do_read(3'd7, 8'h08);
        @(negedge clk) peek("R8 cleared after", 8'h40);

        // R10 reset while pending, then mask must be cleared
        set_din(48'h933457ABCCEE);
        @(negedge clk) peek("R10 pending before reset", 8'h20);
        rst_n = 1'b0;
        #1 peek("R10 in reset", 8'h40);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        set_din(48'h933457ABCCEF);
        @(negedge clk) peek("R10 mask cleared", 8'h40);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule